// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor with Adaptive Selector

This block predicts the direction of conditional branches by running two independent predictors side by side and letting a third table decide which of them to trust. The global-pattern predictor is a table of 2-bit saturating counters addressed by the shift register of recent branch outcomes across the whole program. The per-branch predictor works in two levels. A history table, addressed by instruction address bits, holds the recent outcomes of the branches that map to each entry. That history then selects a 3-bit saturating counter. A selector table of 2-bit counters, addressed by the same global outcome register, picks one of the two component predictions for each branch.

Lookup is purely combinational. A fetch stage presents an address and gets back four things in the same cycle: the final prediction, both component predictions and the selector decision. When the branch resolves, the pipeline returns the address, the real outcome and the two component predictions it saved from lookup. The block then trains every table in one clock edge and shifts the outcome into both history structures. The default sizing is a 12-bit global history, 4096 global counters, 4096 selector counters, 1024 per-branch histories of 10 bits and 1024 3-bit counters. Target prediction and repair of speculative history are left to other blocks.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every global counter holds 1, every 3-bit per-branch counter holds 3, every selector counter holds 1, and all history bits are 0. Every lookup therefore returns global, local and final prediction not-taken, with the selector choosing global (pred_use_local=0).
- R2: The global prediction is the upper bit of the 2-bit counter addressed by the global history, so a value of 2 or more means taken. On every update that counter goes up by one on a taken outcome and down by one otherwise, and it saturates at 0 and 3.
- R3: Each update shifts the actual outcome into bit 0 of the global history. Bit i then holds the outcome of the i-th earlier branch (1 = taken). Older bits move up, and the oldest bit is dropped.
- R4: The per-branch history entry is addressed by lk_pc / upd_pc bits [LHT_IDX_W+1:2]. Each update shifts the outcome into bit 0 of the addressed entry and leaves the other entries unchanged.
- R5: The local prediction is the upper bit of the 3-bit counter addressed by the per-branch history, so a value of 4 or more means taken. On update, the counter addressed by the history as it stood before that update is incremented on taken and decremented otherwise, saturating at 0 and 7.
- R6: The selector counter addressed by the global history chooses the per-branch prediction when its value is 2 or more, and the global prediction otherwise. pred_taken equals the chosen component.
- R7: The selector counter is trained only when upd_gpred differs from upd_lpred. It goes up by one if upd_lpred equals upd_taken and down by one otherwise, saturating at 0 and 3.
- R8: A lookup made in the same cycle as an update sees the table state from before that update. The update becomes visible to lookups from the following cycle onward.
- R9: While upd_valid is 0, no table or history changes, whatever values the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| lk_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Final direction prediction |
| pred_global | output | 1 | Global-history component prediction |
| pred_local | output | 1 | Per-branch-history component prediction |
| pred_use_local | output | 1 | Selector decision, 1 = per-branch component chosen |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_gpred | input | 1 | Global prediction saved at lookup |
| upd_lpred | input | 1 | Per-branch prediction saved at lookup |

## Verification
The case that needs care is a lookup and a training update landing in the same cycle on the same branch address. The read path must return the pre-update counters and histories, and the write must appear only after the edge. The bench provokes this on every step. It holds lk_pc at the branch being trained, raises upd_valid before the edge and checks that the outputs have not moved. On the next step it compares the outputs against a bench-side arithmetic model that applied the update. Some steps deliberately report a wrong saved component prediction, which forces selector training in cases the design would not produce on its own. Other steps idle with garbage on the update inputs.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Counter semantics shared by every table in the predictor.
  function automatic int unsigned weak_not_taken(input int unsigned width);
    return (1 << (width - 1)) - 1;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CINIT = CTR_W'(tp_pkg::weak_not_taken(CTR_W));

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur_q;
  logic [CTR_W-1:0] nxt_d;

  assign rd_ctr = mem[rd_idx];

  // next-state for the addressed entry
  always_comb begin
    cur_q = mem[wr_idx];
    nxt_d = cur_q;
    if (wr_up) begin
      if (cur_q != CMAX) nxt_d = cur_q + 1'b1;
    end else begin
      if (cur_q != '0) nxt_d = cur_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CINIT;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt_d;
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic [HIST_W-1:0] wr_hist,
  input  logic              wr_en,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];
  logic [HIST_W-1:0] nxt_d;

  assign rd_hist = mem[rd_idx];
  assign wr_hist = mem[wr_idx];

  always_comb begin
    nxt_d = {wr_hist[HIST_W-2:0], wr_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt_d;
    end
  end
endmodule

// File: rtl/tp_ghr.sv
module tp_ghr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_bit,
  output logic [W-1:0] hist
);
  logic [W-1:0] hist_q;
  logic [W-1:0] hist_d;

  assign hist = hist_q;

  always_comb begin
    hist_d = {hist_q[W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
  parameter int PC_W      = 32,
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int GCTR_W    = 2,
  parameter int LCTR_W    = 3,
  parameter int SEL_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  output logic            pred_use_local,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_gpred,
  input  logic            upd_lpred
);
  localparam int LIDX_LO = 2;
  localparam int LIDX_HI = LHT_IDX_W + LIDX_LO - 1;

  logic [GHIST_W-1:0]   ghist;
  logic [LHT_IDX_W-1:0] lk_lidx;
  logic [LHT_IDX_W-1:0] upd_lidx;
  logic [LHIST_W-1:0]   lk_lhist;
  logic [LHIST_W-1:0]   upd_lhist;
  logic [GCTR_W-1:0]    g_ctr;
  logic [LCTR_W-1:0]    l_ctr;
  logic [SEL_W-1:0]     s_ctr;
  logic                 sel_en;
  logic                 sel_up;

  assign lk_lidx  = lk_pc[LIDX_HI:LIDX_LO];
  assign upd_lidx = upd_pc[LIDX_HI:LIDX_LO];

  // selector learns only when the components disagreed
  assign sel_en = upd_valid && (upd_gpred != upd_lpred);
  assign sel_up = (upd_lpred == upd_taken);

  tp_ghr #(.W(GHIST_W)) u_ghr (
    .clk(clk), .rst_n(rst_n), .shift_en(upd_valid), .shift_bit(upd_taken),
    .hist(ghist)
  );

  tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_lidx), .rd_hist(lk_lhist),
    .wr_idx(upd_lidx), .wr_hist(upd_lhist), .wr_en(upd_valid),
    .wr_bit(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gtab (
    .clk(clk), .rst_n(rst_n), .rd_idx(ghist), .rd_ctr(g_ctr),
    .wr_en(upd_valid), .wr_idx(ghist), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_ltab (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_lhist), .rd_ctr(l_ctr),
    .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .rd_idx(ghist), .rd_ctr(s_ctr),
    .wr_en(sel_en), .wr_idx(ghist), .wr_up(sel_up)
  );

  assign pred_global    = g_ctr[GCTR_W-1];
  assign pred_local     = l_ctr[LCTR_W-1];
  assign pred_use_local = s_ctr[SEL_W-1];
  assign pred_taken     = pred_use_local ? pred_local : pred_global;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int PC_W      = 32,
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 upd_valid,
  input logic                 upd_taken,
  input logic [PC_W-1:0]      lk_pc,
  input logic [GHIST_W-1:0]   ghist,
  input logic [LHT_IDX_W-1:0] lk_lidx,
  input logic [LHT_IDX_W-1:0] upd_lidx,
  input logic [LHIST_W-1:0]   lk_lhist,
  input logic                 pred_taken,
  input logic                 pred_global,
  input logic                 pred_local
);
  // R3
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)});

  // R9
  ghist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  // R9
  pred_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($past(lk_pc) != lk_pc) ||
                   ($stable(pred_taken) && $stable(pred_global) && $stable(pred_local)));

  // R4
  lhist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && lk_lidx == upd_lidx) |=> ($past(lk_lidx) != lk_lidx) ||
      (lk_lhist == {$past(lk_lhist[LHIST_W-2:0]), $past(upd_taken)}));
endmodule

bind tournament_predictor tp_checker #(
  .PC_W(PC_W), .GHIST_W(GHIST_W), .LHT_IDX_W(LHT_IDX_W), .LHIST_W(LHIST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .lk_pc(lk_pc), .ghist(ghist), .lk_lidx(lk_lidx), .upd_lidx(upd_lidx),
  .lk_lhist(lk_lhist), .pred_taken(pred_taken), .pred_global(pred_global),
  .pred_local(pred_local)
);

// File: tb/tb_tournament_predictor.sv
module tb_tournament_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int GH    = 4;
  localparam int LI    = 3;
  localparam int LH    = 3;
  localparam int STEPS = 4000;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc;
  logic            pred_taken, pred_global, pred_local, pred_use_local;
  logic            upd_valid;
  logic [PC_W-1:0] upd_pc;
  logic            upd_taken, upd_gpred, upd_lpred;

  int errors = 0;
  int checks = 0;

  // bench-side model state
  int m_g   [1<<GH];
  int m_c   [1<<GH];
  int m_l   [1<<LH];
  int m_lht [1<<LI];
  int m_gh;
  logic [31:0] rng = 32'h1234_5678;

  tournament_predictor #(
    .PC_W(PC_W), .GHIST_W(GH), .LHT_IDX_W(LI), .LHIST_W(LH)
  ) dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken),
    .pred_global(pred_global), .pred_local(pred_local),
    .pred_use_local(pred_use_local), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_gpred(upd_gpred), .upd_lpred(upd_lpred)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] nxt_rng(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v, input bit up, input int mx);
    if (up) return (v == mx) ? v : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic m_update(input int idx, input bit tk, input bit gp, input bit lp);
    int lh = m_lht[idx];
    m_g[m_gh] = sat(m_g[m_gh], tk, 3);          // R2
    m_l[lh]   = sat(m_l[lh], tk, 7);            // R5
    if (gp != lp) m_c[m_gh] = sat(m_c[m_gh], (lp == tk), 3); // R7
    m_lht[idx] = ((lh << 1) | int'(tk)) & ((1 << LH) - 1);   // R4
    m_gh       = ((m_gh << 1) | int'(tk)) & ((1 << GH) - 1); // R3
  endtask

  task automatic cmp_model(input int idx, input string tag);
    bit eg = (m_g[m_gh] >= 2);
    bit el = (m_l[m_lht[idx]] >= 4);
    bit es = (m_c[m_gh] >= 2);
    chk({tag, " R2 R3 global"}, pred_global, eg);
    chk({tag, " R4 R5 local"}, pred_local, el);
    chk({tag, " R7 selector"}, pred_use_local, es);
    chk({tag, " R6 final"}, pred_taken, es ? el : eg);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_pc = '0; upd_valid = 1'b0; upd_pc = '0;
    upd_taken = 1'b0; upd_gpred = 1'b0; upd_lpred = 1'b0;
    for (int i = 0; i < (1<<GH); i++) begin m_g[i] = 1; m_c[i] = 1; end
    for (int i = 0; i < (1<<LH); i++) m_l[i] = 3;
    for (int i = 0; i < (1<<LI); i++) m_lht[i] = 0;
    m_gh = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state seen from every per-branch entry
    for (int i = 0; i < (1<<LI); i++) begin
      @(negedge clk) lk_pc = PC_W'(i << 2);
      #1;
      chk("R1 global", pred_global, 1'b0);
      chk("R1 local", pred_local, 1'b0);
      chk("R1 selector", pred_use_local, 1'b0);
      chk("R1 final", pred_taken, 1'b0);
    end

    for (int s = 0; s < STEPS; s++) begin
      int  idx;
      bit  tk, gp, lp, idle;
      rng  = nxt_rng(rng);
      idx  = (s < 400) ? 0 : int'(rng[2:0]);
      if (s < 40)        tk = 1'b1;                          // saturate upward
      else if (s < 80)   tk = 1'b0;                          // saturate downward
      else if (s < 2000) tk = ((s / (idx + 1)) % 2) == 0;    // per-branch periodic
      else               tk = rng[9];
      idle = (rng[15:12] == 4'd0);

      @(negedge clk);
      lk_pc     = {rng[31:8], 3'(idx), 2'b00} & {PC_W{1'b1}};
      upd_valid = 1'b0;
      #1;
      cmp_model(idx, "step");
      gp = pred_global;
      lp = pred_local;
      if (s % 7 == 3) lp = ~lp;   // stale saved prediction forces selector training

      if (idle) begin
        // R9: garbage update inputs without the strobe
        upd_pc = ~lk_pc; upd_taken = rng[20]; upd_gpred = rng[21]; upd_lpred = rng[22];
        @(negedge clk);
        #1;
        cmp_model(idx, "R9 idle");
      end

      upd_pc = lk_pc; upd_taken = tk; upd_gpred = gp; upd_lpred = lp;
      upd_valid = 1'b1;
      #1;
      // R8: same-cycle lookup still returns the pre-update view
      cmp_model(idx, "R8 same-cycle");
      @(posedge clk);
      m_update(idx, tk, gp, lp);
    end

    @(negedge clk) upd_valid = 1'b0;
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule